// File: doc/BRIEF.md
# Panel-Meter Display Source Selector

This block decides which value a multi-digit LED panel meter shows and how each digit is rendered. It receives signed conversion results from the measurement path, a display word written by the host, per-digit segment patterns and a small control word. It keeps a running peak of the largest-magnitude result and an overrange threshold, and it raises a sticky overrange flag when a result goes past that threshold in either direction.

The host programs the block through a parallel write port. Register map (address: content): 0 is control (bit 0 hold, bit 1 peak view, bit 2 host-word view, bit 3 segment mode, bit 4 clear-arm); 1 is the host display word; 2 is the overrange threshold; 3 + i is the 8-bit segment pattern of digit i (low byte of the write data). Digit 0 is the least significant and digit `FULL_DIGITS` is the leading half digit. The display word goes to the downstream digit renderer together with a 2-bit code per digit: 0 renders the numeral from the display word, 1 forces a "1", 2 forces a dash, 3 drives the digit from its segment pattern.

Top module: `disp_src_sel`

## Requirements
- R1: After reset the display word is 0, every digit code is 0, the overrange flag is 0 and all segment patterns are 0.
- R2: With hold, peak view and host-word view all 0, each valid result appears on the display word at the clock edge that accepts it.
- R3: With host-word view 1 and hold and peak view 0, the display word follows the host display word register and the digit codes are all 0.
- R4: The peak register takes a valid result whose magnitude is strictly greater than its own; with peak view 1 and hold 0 the display word shows the peak register one cycle after it changes.
- R5: With hold 1 the display word and overrange rendering do not change, while results keep updating the peak register.
- R6: Display source priority is hold, then peak view, then host-word view, then live result; segment mode overrides the rendering so every digit code is 3 and the segment patterns are presented on the segment output.
- R7: The overrange flag sets when a valid result's magnitude exceeds the threshold's magnitude (negative results included), stays set while results return in range, clears only on a clear pulse, and a new overrange result in the same cycle as a clear pulse wins.
- R8: When the displayed result or peak exceeds the threshold in magnitude and segment mode is 0, the leading digit code is 1 and every other digit code is 2.
- R9: The threshold resets to 2*10^FULL_DIGITS-1 (1999 or 19999) and is rewritable at address 2; a result equal to the threshold is not overrange.
- R10: A clear-arm bit of 1 has no effect until a rising edge of the chip-select input; at that edge every register, including the peak, display and overrange flag, returns to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select; rising edge applies an armed clear |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Register write data |
| res_valid_i | input | 1 | Conversion result valid |
| res_data_i | input | DATA_W | Conversion result, two's complement |
| over_clr_i | input | 1 | Overrange flag clear pulse |
| disp_word_o | output | DATA_W | Selected display word |
| seg_pat_o | output | 8*(FULL_DIGITS+1) | Segment patterns, digit i at bits 8i+7:8i |
| digit_code_o | output | 2*(FULL_DIGITS+1) | Per-digit render code, digit i at bits 2i+1:2i |
| over_o | output | 1 | Sticky overrange flag |

## Verification
The bench builds the block with FULL_DIGITS = 4 and the default 16-bit data width, so five digits exist and the reset threshold is 19999. That brings the five-digit overrange pattern, the boundary pair 19999/20000, and the restoration of the wider reset threshold after a chip-select clear within reach, along with the magnitude compare on values near the negative limit.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    DIG_NUM  = 2'd0,
    DIG_ONE  = 2'd1,
    DIG_DASH = 2'd2,
    DIG_SEG  = 2'd3
  } dig_code_e;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_HOST = 1;
  localparam int unsigned A_THR  = 2;
  localparam int unsigned A_SEG0 = 3;
  localparam int unsigned CTRL_W = 5;

  typedef struct packed {
    logic clear;
    logic seg_mode;
    logic host_sel;
    logic peak;
    logic hold;
  } ctrl_t;
endpackage

// File: rtl/dss_regs.sv
module dss_regs
  import dss_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_DIG = 4,
  parameter int unsigned ADDR_W  = 3,
  parameter logic [DATA_W-1:0] THR_RST = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output ctrl_t                 ctrl_o,
  output logic [DATA_W-1:0]     host_o,
  output logic [DATA_W-1:0]     thr_o,
  output logic [NUM_DIG*8-1:0]  seg_o,
  output logic                  clr_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] host_q, thr_q;
  logic              cs_q;

  assign clr_o = ctrl_q.clear & cs_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= cs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      host_q <= '0;
      thr_q  <= THR_RST;
    end else if (clr_o) begin
      ctrl_q <= '0;
      host_q <= '0;
      thr_q  <= THR_RST;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(A_CTRL)) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_addr_i == ADDR_W'(A_HOST)) host_q <= wr_data_i;
      if (wr_addr_i == ADDR_W'(A_THR))  thr_q  <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_seg
    logic [7:0] seg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          seg_q <= '0;
      else if (clr_o)                                       seg_q <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(A_SEG0 + g)) seg_q <= wr_data_i[7:0];
    end
    assign seg_o[g*8 +: 8] = seg_q;
  end

  assign ctrl_o = ctrl_q;
  assign host_o = host_q;
  assign thr_o  = thr_q;

  a_r10_clear_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> (ctrl_q == '0 && thr_q == THR_RST && host_q == '0));
endmodule

// File: rtl/dss_peak_over.sv
module dss_peak_over #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic              over_clr_i,
  output logic [DATA_W-1:0] peak_o,
  output logic              over_o
);
  function automatic logic [DATA_W:0] mag(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? ({1'b0, ~v} + (DATA_W+1)'(1)) : {1'b0, v};
  endfunction

  logic [DATA_W-1:0] peak_q;
  logic              over_q;
  logic              res_big, res_over;

  assign res_big  = res_valid_i && (mag(res_data_i) > mag(peak_q));
  assign res_over = res_valid_i && (mag(res_data_i) > mag(thr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      peak_q <= '0;
    else if (clr_i)   peak_q <= '0;
    else if (res_big) peak_q <= res_data_i;
  end

  // set beats clear pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         over_q <= 1'b0;
    else if (clr_i)      over_q <= 1'b0;
    else if (res_over)   over_q <= 1'b1;
    else if (over_clr_i) over_q <= 1'b0;
  end

  assign peak_o = peak_q;
  assign over_o = over_q;

  a_r4_peak_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> mag(peak_q) >= mag($past(peak_q)));
  a_r7_over_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_q && !over_clr_i && !clr_i) |=> over_q);
  a_r7_over_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !clr_i && mag(res_data_i) > mag(thr_i)) |=> over_q);
endmodule

// File: rtl/dss_sel.sv
module dss_sel
  import dss_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned NUM_DIG = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  ctrl_t                 ctrl_i,
  input  logic [DATA_W-1:0]     host_i,
  input  logic [DATA_W-1:0]     thr_i,
  input  logic [DATA_W-1:0]     peak_i,
  input  logic                  res_valid_i,
  input  logic [DATA_W-1:0]     res_data_i,
  output logic [DATA_W-1:0]     disp_o,
  output logic [NUM_DIG*2-1:0]  code_o
);
  function automatic logic [DATA_W:0] mag(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? ({1'b0, ~v} + (DATA_W+1)'(1)) : {1'b0, v};
  endfunction

  logic [DATA_W-1:0] disp_q;
  logic              ovr_q;

  // priority: hold > peak > host word > live result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= '0;
      ovr_q  <= 1'b0;
    end else if (clr_i) begin
      disp_q <= '0;
      ovr_q  <= 1'b0;
    end else if (ctrl_i.hold) begin
      disp_q <= disp_q;
    end else if (ctrl_i.peak) begin
      disp_q <= peak_i;
      ovr_q  <= mag(peak_i) > mag(thr_i);
    end else if (ctrl_i.host_sel) begin
      disp_q <= host_i;
      ovr_q  <= 1'b0;
    end else if (res_valid_i) begin
      disp_q <= res_data_i;
      ovr_q  <= mag(res_data_i) > mag(thr_i);
    end
  end

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_code
    dig_code_e code;
    always_comb begin
      if (ctrl_i.seg_mode)      code = DIG_SEG;
      else if (!ovr_q)          code = DIG_NUM;
      else if (g == NUM_DIG-1)  code = DIG_ONE;
      else                      code = DIG_DASH;
    end
    assign code_o[g*2 +: 2] = code;
  end

  assign disp_o = disp_q;

  a_r5_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.hold && !clr_i) |=> ($stable(disp_q) && $stable(ovr_q)));
  a_r2_live_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ctrl_i.hold && !ctrl_i.peak && !ctrl_i.host_sel && res_valid_i)
      |=> disp_q == $past(res_data_i));
endmodule

// File: rtl/disp_src_sel.sv
module disp_src_sel
  import dss_pkg::*;
#(
  parameter int unsigned FULL_DIGITS = 3,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned NUM_DIG    = FULL_DIGITS + 1,
  localparam int unsigned ADDR_W     = $clog2(A_SEG0 + NUM_DIG)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  res_valid_i,
  input  logic [DATA_W-1:0]     res_data_i,
  input  logic                  over_clr_i,
  output logic [DATA_W-1:0]     disp_word_o,
  output logic [NUM_DIG*8-1:0]  seg_pat_o,
  output logic [NUM_DIG*2-1:0]  digit_code_o,
  output logic                  over_o
);
  function automatic longint pow10(input int unsigned n);
    longint r = 1;
    for (int unsigned i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  localparam logic [DATA_W-1:0] THR_RST = DATA_W'(2 * pow10(FULL_DIGITS) - 1);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] host, thr, peak;
  logic              clr;

  dss_regs #(
    .DATA_W(DATA_W), .NUM_DIG(NUM_DIG), .ADDR_W(ADDR_W), .THR_RST(THR_RST)
  ) i_regs (
    .clk_i, .rst_ni, .cs_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .host_o(host), .thr_o(thr), .seg_o(seg_pat_o), .clr_o(clr)
  );

  dss_peak_over #(.DATA_W(DATA_W)) i_peak_over (
    .clk_i, .rst_ni, .clr_i(clr), .res_valid_i, .res_data_i,
    .thr_i(thr), .over_clr_i, .peak_o(peak), .over_o
  );

  dss_sel #(.DATA_W(DATA_W), .NUM_DIG(NUM_DIG)) i_sel (
    .clk_i, .rst_ni, .clr_i(clr), .ctrl_i(ctrl), .host_i(host), .thr_i(thr),
    .peak_i(peak), .res_valid_i, .res_data_i,
    .disp_o(disp_word_o), .code_o(digit_code_o)
  );

  a_r10_clear_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!over_o && disp_word_o == '0 && seg_pat_o == '0));
endmodule

// File: tb/test_disp_src_sel.sv
module test_disp_src_sel;
  localparam int unsigned FD = 4;
  localparam int unsigned ND = FD + 1;
  localparam int unsigned AW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [15:0]   wr_data_i = '0;
  logic          res_valid_i = 1'b0;
  logic [15:0]   res_data_i = '0;
  logic          over_clr_i = 1'b0;
  logic [15:0]   disp_word_o;
  logic [ND*8-1:0] seg_pat_o;
  logic [ND*2-1:0] digit_code_o;
  logic          over_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  localparam logic [ND*2-1:0] CODE_NUM  = '0;
  localparam logic [ND*2-1:0] CODE_SEG  = '1;
  localparam logic [ND*2-1:0] CODE_OVER = 10'b01_10_10_10_10;

  always #2 clk = ~clk;

  disp_src_sel #(.FULL_DIGITS(FD)) i_disp_src_sel (
    .clk_i(clk), .rst_ni, .cs_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .res_valid_i, .res_data_i, .over_clr_i,
    .disp_word_o, .seg_pat_o, .digit_code_o, .over_o
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic res(input logic [15:0] d);
    res_valid_i = 1'b1; res_data_i = d;
    step();
    res_valid_i = 1'b0;
  endtask

  task automatic oclr();
    over_clr_i = 1'b1; step(); over_clr_i = 1'b0;
  endtask

  task automatic cs_clear();
    wr(0, 16'h0010);
    cs_i = 1'b1; step(); cs_i = 1'b0; step();
  endtask

  task automatic t_reset();
    chk("R1 disp", disp_word_o, 0);
    chk("R1 codes", digit_code_o, CODE_NUM);
    chk("R1 over", over_o, 0);
    chk("R1 seg", seg_pat_o, 0);
  endtask

  task automatic t_live();
    res(16'd1234);
    chk("R2 disp 1234", disp_word_o, 16'd1234);
    res(-16'sd77);
    chk("R2 disp -77", disp_word_o, 16'hFFB3);
    chk("R2 codes", digit_code_o, CODE_NUM);
  endtask

  task automatic t_over();
    res(16'd19999);
    chk("R9 at threshold over", over_o, 0);
    chk("R9 at threshold codes", digit_code_o, CODE_NUM);
    res(16'd20000);
    chk("R7 over set", over_o, 1);
    chk("R8 over codes", digit_code_o, CODE_OVER);
    res(16'd5);
    chk("R7 over sticky", over_o, 1);
    chk("R8 codes back", digit_code_o, CODE_NUM);
    oclr();
    chk("R7 over cleared", over_o, 0);
    res(-16'sd20000);
    chk("R7 negative over", over_o, 1);
    chk("R8 negative codes", digit_code_o, CODE_OVER);
    oclr();
    res_valid_i = 1'b1; res_data_i = 16'h8000; over_clr_i = 1'b1;
    step();
    res_valid_i = 1'b0; over_clr_i = 1'b0;
    chk("R7 set wins clear", over_o, 1);
    oclr();
    wr(2, 16'd100);
    res(16'd100);
    chk("R9 new threshold equal", over_o, 0);
    res(16'd101);
    chk("R9 new threshold over", over_o, 1);
    oclr();
  endtask

  task automatic t_host();
    wr(1, 16'h1A2B);
    wr(0, 16'h0004);
    step();
    chk("R3 host word", disp_word_o, 16'h1A2B);
    res(16'd50);
    chk("R3 result ignored", disp_word_o, 16'h1A2B);
    chk("R3 codes", digit_code_o, CODE_NUM);
  endtask

  task automatic t_peak();
    cs_clear();
    res(16'd50); res(-16'sd300); res(16'd200); res(16'd300);
    wr(0, 16'h0002);
    step();
    chk("R4 peak shown", disp_word_o, 16'hFED4);
    res(16'd301);
    step();
    chk("R4 peak follows", disp_word_o, 16'd301);
  endtask

  task automatic t_hold();
    wr(0, 16'h0003);
    res(-16'sd900);
    step(); step();
    chk("R5 held", disp_word_o, 16'd301);
    wr(0, 16'h0002);
    step();
    chk("R5 peak ran during hold", disp_word_o, 16'hFC7C);
  endtask

  task automatic t_prio();
    wr(1, 16'h0BCD);
    wr(0, 16'h0006);
    step();
    chk("R6 peak over host", disp_word_o, 16'hFC7C);
    wr(0, 16'h0004);
    step();
    chk("R6 host over live", disp_word_o, 16'h0BCD);
    wr(0, 16'h0005);
    wr(1, 16'h0111);
    step();
    chk("R6 hold over host", disp_word_o, 16'h0BCD);
    for (int i = 0; i < ND; i++) wr(3 + i, 16'(17 * (i + 1)));
    wr(0, 16'h000F);
    step();
    chk("R6 seg codes", digit_code_o, CODE_SEG);
    for (int i = 0; i < ND; i++) chk("R6 seg pattern", seg_pat_o[i*8 +: 8], 8'(17 * (i + 1)));
  endtask

  task automatic t_clear();
    wr(0, 16'h0000);
    res(16'd30000);
    chk("R10 pre over", over_o, 1);
    wr(0, 16'h0010);
    step(); step();
    chk("R10 no cs edge over", over_o, 1);
    chk("R10 no cs edge disp", disp_word_o, 16'd30000);
    cs_i = 1'b1; step(); cs_i = 1'b0; step();
    chk("R10 over cleared", over_o, 0);
    chk("R10 disp cleared", disp_word_o, 0);
    chk("R10 seg cleared", seg_pat_o, 0);
    res(16'd19999);
    chk("R10 threshold restored", over_o, 0);
    chk("R10 live after clear", disp_word_o, 16'd19999);
  endtask

  initial begin
    #1;
    step(); step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_live();
    t_over();
    t_host();
    t_peak();
    t_hold();
    t_prio();
    t_clear();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule